// File: doc/BRIEF.md
# Multi-Channel Timer PWM Bank

This block holds a bank of independent 16-bit timer channels. Each channel drives one PWM pin. Software sets each channel through a single-cycle register port. Every channel has four registers: control, duty compare, period, and a counter that software may write directly. Two shared bitmask registers start and stop the counters: one sets running bits, the other clears them.

The counter of a running channel advances by one on each strobe of that channel's clock enable. When the count equals the period value, the counter returns to zero, so one waveform cycle lasts period+1 strobes. The pin rests at the channel's initial level. It takes the opposite level while duty ≤ count < period and holds the initial level at all other times.

Clearing the output enable forces the initial level at the pin. This takes effect at once in abrupt mode. In graceful mode it waits until the counter wraps at the period match.

Top module: `tmr_pwm_bank`

## Requirements
- R1: After a synchronous active-high reset, every channel register reads 0, all counters are stopped (running mask reads 0), every pin is 0 and the read port returns 0.
- R2: Writing the start register (address 0x00) sets running bit n for each data bit n that is 1. Bits written as 0 leave their running bits unchanged. A read of address 0x00 returns the running mask in the low bits.
- R3: Writing the stop register (address 0x01) clears running bit n for each data bit n that is 1. Bits written as 0 have no effect. A stopped counter holds its value whatever its clock-enable strobe does.
- R4: A running counter advances by one on each cycle in which its clock-enable strobe is high. On a strobe while the count equals the period, it goes to 0, so one cycle lasts period+1 strobes.
- R5: With output enable set (control bit 1), the pin shows the inverse of the initial level while duty ≤ count < period, and the initial level otherwise. The pin follows the register contents in the cycle after they change.
- R6: Control bit 0 selects the initial level: 1 gives high, 0 gives low.
- R7: When duty is greater than period, the pin stays at the initial level for the whole cycle.
- R8: With control bit 2 (abrupt) set, a control write that clears output enable puts the initial level on the pin in the next cycle.
- R9: With bit 2 clear (graceful), clearing output enable keeps the waveform until the counter wraps at the period match. After that the pin holds the initial level.
- R10: Writing a channel's counter register loads it. A counter write in the same cycle as a clock-enable strobe takes priority, and that strobe is lost.
- R11: Channel c occupies addresses 4(c+1) through 4(c+1)+3: control (bits 2:0), duty, period and counter. Each reads back one cycle after its address is presented. Addresses of unimplemented channels and unused global offsets read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | NUM_CH | Per-channel count-enable strobes |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | AW | Register address, used for both reads and writes |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Registered read data for the address of the previous cycle |
| pwm_out | output | NUM_CH | Registered PWM pins |

## Verification
A direct write to a channel's counter and a count-enable strobe for that channel can land in the same cycle. The bench provokes this by issuing the counter write with the strobe held high. It reads the counter back and expects the written value, not that value plus one. A later lone strobe must then advance the counter by exactly one. A graceful output-enable clear also meets the period wrap in a later cycle. That case is judged by checking that the pin keeps its waveform up to the wrap and holds the initial level on the count after it.

// File: rtl/tmr_pwm_pkg.sv
package tmr_pwm_pkg;

  // control register layout, bit 0 upward: init level, output enable, abrupt stop
  typedef struct packed {
    logic abrupt;
    logic out_en;
    logic init_high;
  } chan_ctrl_t;

  localparam int unsigned CTRL_W = $bits(chan_ctrl_t);

  // word offsets inside a channel slot
  localparam logic [1:0] OFF_CTRL   = 2'd0;
  localparam logic [1:0] OFF_DUTY   = 2'd1;
  localparam logic [1:0] OFF_PERIOD = 2'd2;
  localparam logic [1:0] OFF_COUNT  = 2'd3;

  // word offsets inside the global slot (slot 0)
  localparam logic [1:0] GLB_START  = 2'd0;
  localparam logic [1:0] GLB_STOP   = 2'd1;

endpackage

// File: rtl/tmr_pwm_decode.sv
module tmr_pwm_decode
  import tmr_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned AW     = 6
) (
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  output logic              start_wr,
  output logic              stop_wr,
  output logic [NUM_CH-1:0] ctrl_we,
  output logic [NUM_CH-1:0] duty_we,
  output logic [NUM_CH-1:0] period_we,
  output logic [NUM_CH-1:0] count_we
);

  localparam int unsigned SLOT_W = AW - 2;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        off;
  logic              glb_hit;

  assign slot    = addr[AW-1:2];
  assign off     = addr[1:0];
  assign glb_hit = wr && (slot == '0);

  assign start_wr = glb_hit && (off == GLB_START);
  assign stop_wr  = glb_hit && (off == GLB_STOP);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan_dec
    logic hit;
    assign hit          = wr && (slot == SLOT_W'(c + 1));
    assign ctrl_we[c]   = hit && (off == OFF_CTRL);
    assign duty_we[c]   = hit && (off == OFF_DUTY);
    assign period_we[c] = hit && (off == OFF_PERIOD);
    assign count_we[c]  = hit && (off == OFF_COUNT);
  end

  // R11: a single write reaches at most one register
  always_comb begin
    a_r11_single_target: assert ($onehot0({start_wr, stop_wr, ctrl_we, duty_we, period_we, count_we}))
      else $error("R11: more than one write target decoded");
  end

endmodule

// File: rtl/tmr_pwm_runmask.sv
module tmr_pwm_runmask #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic              stop_wr,
  input  logic [NUM_CH-1:0] wmask,
  output logic [NUM_CH-1:0] run
);

  logic [NUM_CH-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (start_wr) begin
      run_q <= run_q | wmask;
    end else if (stop_wr) begin
      run_q <= run_q & ~wmask;
    end
  end

  assign run = run_q;

  a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
    start_wr |=> ((run_q & $past(wmask)) == $past(wmask)));

  a_r2_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    start_wr |=> (($past(run_q) & ~run_q) == '0));

  a_r3_clear_bits: assert property (@(posedge clk) disable iff (rst)
    stop_wr |=> ((run_q & $past(wmask)) == '0));

  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    stop_wr |=> ((run_q & ~$past(run_q)) == '0));

endmodule

// File: rtl/tmr_pwm_chan.sv
module tmr_pwm_chan
  import tmr_pwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          wr_ctrl,
  input  logic          wr_duty,
  input  logic          wr_period,
  input  logic          wr_count,
  input  logic [CW-1:0] wdata,
  output chan_ctrl_t    ctrl,
  output logic [CW-1:0] duty,
  output logic [CW-1:0] period,
  output logic [CW-1:0] count,
  output logic          pin
);

  chan_ctrl_t    ctrl_q, ctrl_n;
  logic [CW-1:0] duty_q, duty_n;
  logic [CW-1:0] period_q, period_n;
  logic [CW-1:0] count_q, count_n;
  logic          drive_q, drive_n;
  logic          pin_q, pin_n;
  logic          advance, at_end, wrap_ev, active_n;

  always_comb begin
    ctrl_n   = wr_ctrl   ? chan_ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;
    duty_n   = wr_duty   ? wdata : duty_q;
    period_n = wr_period ? wdata : period_q;

    // a direct counter write wins over a strobe in the same cycle
    advance  = run && tick && !wr_count;
    at_end   = (count_q == period_q);
    wrap_ev  = advance && at_end;

    if (wr_count)      count_n = wdata;
    else if (wrap_ev)  count_n = '0;
    else if (advance)  count_n = count_q + 1'b1;
    else               count_n = count_q;

    // drive stays up after enable drops until abrupt mode or a period wrap
    drive_n  = ctrl_n.out_en || (drive_q && !ctrl_n.abrupt && !wrap_ev);

    // inverted phase spans duty..period-1; empty when duty >= period
    active_n = (count_n >= duty_n) && (count_n < period_n);
    pin_n    = ctrl_n.init_high ^ (drive_n && active_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      duty_q   <= '0;
      period_q <= '0;
      count_q  <= '0;
      drive_q  <= 1'b0;
      pin_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_n;
      duty_q   <= duty_n;
      period_q <= period_n;
      count_q  <= count_n;
      drive_q  <= drive_n;
      pin_q    <= pin_n;
    end
  end

  assign ctrl   = ctrl_q;
  assign duty   = duty_q;
  assign period = period_q;
  assign count  = count_q;
  assign pin    = pin_q;

  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_count) |=> $stable(count_q));

  a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !wr_count && (count_q != period_q)) |=> (count_q == $past(count_q) + 1'b1));

  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !wr_count && (count_q == period_q)) |=> (count_q == '0));

  a_r10_count_load: assert property (@(posedge clk) disable iff (rst)
    wr_count |=> (count_q == $past(wdata)));

  a_r7_no_compare: assert property (@(posedge clk) disable iff (rst)
    (duty_q > period_q) |-> (pin_q == ctrl_q.init_high));

  a_r8_abrupt_off: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wdata[2] && !wdata[1]) |=> (pin_q == ctrl_q.init_high));

  a_r5_idle_level: assert property (@(posedge clk) disable iff (rst)
    (count_q < duty_q) |-> (pin_q == ctrl_q.init_high));

endmodule

// File: rtl/tmr_pwm_bank.sv
module tmr_pwm_bank
  import tmr_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CW     = 16,
  parameter int unsigned AW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] tick,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [CW-1:0]     bus_wdata,
  output logic [CW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int unsigned SLOT_W = AW - 2;

  logic              start_wr, stop_wr;
  logic [NUM_CH-1:0] ctrl_we, duty_we, period_we, count_we;
  logic [NUM_CH-1:0] run;

  chan_ctrl_t        ctrl_arr   [NUM_CH];
  logic [CW-1:0]     duty_arr   [NUM_CH];
  logic [CW-1:0]     period_arr [NUM_CH];
  logic [CW-1:0]     count_arr  [NUM_CH];
  logic [NUM_CH-1:0] pin_vec;

  logic [CW-1:0]     rd_next, rdata_q;
  logic [SLOT_W-1:0] rd_slot;
  logic [1:0]        rd_off;

  tmr_pwm_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_decode (
    .wr        (bus_wr),
    .addr      (bus_addr),
    .start_wr  (start_wr),
    .stop_wr   (stop_wr),
    .ctrl_we   (ctrl_we),
    .duty_we   (duty_we),
    .period_we (period_we),
    .count_we  (count_we)
  );

  tmr_pwm_runmask #(.NUM_CH(NUM_CH)) u_runmask (
    .clk      (clk),
    .rst      (rst),
    .start_wr (start_wr),
    .stop_wr  (stop_wr),
    .wmask    (bus_wdata[NUM_CH-1:0]),
    .run      (run)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    tmr_pwm_chan #(.CW(CW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick[c]),
      .run       (run[c]),
      .wr_ctrl   (ctrl_we[c]),
      .wr_duty   (duty_we[c]),
      .wr_period (period_we[c]),
      .wr_count  (count_we[c]),
      .wdata     (bus_wdata),
      .ctrl      (ctrl_arr[c]),
      .duty      (duty_arr[c]),
      .period    (period_arr[c]),
      .count     (count_arr[c]),
      .pin       (pin_vec[c])
    );
  end

  assign rd_slot = bus_addr[AW-1:2];
  assign rd_off  = bus_addr[1:0];

  always_comb begin
    rd_next = '0;
    if (rd_slot == '0) begin
      if (rd_off == GLB_START) rd_next = CW'(run);
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (rd_slot == SLOT_W'(c + 1)) begin
          case (rd_off)
            OFF_CTRL:   rd_next = CW'(ctrl_arr[c]);
            OFF_DUTY:   rd_next = duty_arr[c];
            OFF_PERIOD: rd_next = period_arr[c];
            default:    rd_next = count_arr[c];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign pwm_out   = pin_vec;

  a_r1_reset_clean: assert property (@(posedge clk)
    $past(rst) |-> (bus_rdata == '0 && pwm_out == '0 && run == '0));

endmodule

// File: tb/test_tmr_pwm_bank.sv
`timescale 1ns/1ps
module test_tmr_pwm_bank;

  localparam int NCH = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] tick = '0;
  logic           bus_wr = 1'b0;
  logic [5:0]     bus_addr = '0;
  logic [15:0]    bus_wdata = '0;
  logic [15:0]    bus_rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        rd_stb = 1'b0;
  logic        rd_stb_d = 1'b0;

  always #2 clk = ~clk;

  tmr_pwm_bank #(.NUM_CH(NCH), .CW(16), .AW(6)) i_tmr_pwm_bank (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  // monitor: pops the scoreboard when a read result is due
  always @(posedge clk) rd_stb_d <= rd_stb;

  always @(negedge clk) begin
    if (rd_stb_d) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic [NCH-1:0] tk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick = '0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    bus_addr = a; rd_stb = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic step(input logic [NCH-1:0] tk);
    @(negedge clk);
    tick = tk;
    @(negedge clk);
    tick = '0;
  endtask

  task automatic chk_pin(input logic e, input string t);
    checks++;
    if (pwm_out[0] !== e) begin
      errors++;
      $display("FAIL %s pin actual=%b expected=%b", t, pwm_out[0], e);
    end
  endtask

  // channel 0 addresses
  localparam logic [5:0] A_START = 6'h00, A_STOP = 6'h01;
  localparam logic [5:0] A_CTRL = 6'h04, A_DUTY = 6'h05, A_PER = 6'h06, A_CNT = 6'h07;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    checks++;
    if (pwm_out !== '0) begin
      errors++; $display("FAIL R1 pins actual=%b expected=0", pwm_out);
    end
    rd(A_START, 16'h0000, "R1 run mask");
    rd(A_CNT,   16'h0000, "R1 counter");
    rd(A_PER,   16'h0000, "R1 period");

    // configure ch0: period 4, duty 2, enabled, init low
    wr(A_PER,  16'd4, '0);
    wr(A_DUTY, 16'd2, '0);
    wr(A_CTRL, 16'h0002, '0);
    step(6'h01);
    rd(A_CNT, 16'd0, "R3 stopped counter ignores tick");

    // R2 start
    wr(A_START, 16'h0001, '0);
    rd(A_START, 16'h0001, "R2 start bit");
    wr(A_START, 16'h0000, '0);
    rd(A_START, 16'h0001, "R2 zero bits no effect");

    // R4/R5 waveform: counts 1,2,3,4,0,1
    step(6'h01); chk_pin(1'b0, "R5 c1");
    step(6'h01); chk_pin(1'b1, "R5 c2");
    step(6'h01); chk_pin(1'b1, "R5 c3");
    step(6'h01); chk_pin(1'b0, "R5 c4");
    step(6'h01); chk_pin(1'b0, "R5 c0");
    rd(A_CNT, 16'd0, "R4 wrap after period+1 ticks");
    step(6'h01); chk_pin(1'b0, "R5 c1 again");

    // R6 init high
    wr(A_CTRL, 16'h0003, '0); chk_pin(1'b1, "R6 c1 init high");
    step(6'h01); chk_pin(1'b0, "R6 c2");
    step(6'h01); chk_pin(1'b0, "R6 c3");
    step(6'h01); chk_pin(1'b1, "R6 c4");

    // R3 stop
    wr(A_STOP, 16'h0001, '0);
    rd(A_START, 16'h0000, "R3 stop bit");
    step(6'h01); step(6'h01); step(6'h01);
    rd(A_CNT, 16'd4, "R3 counter holds");
    chk_pin(1'b1, "R3 pin holds");
    wr(A_START, 16'h0003, '0);
    wr(A_STOP,  16'h0000, '0);
    rd(A_START, 16'h0003, "R3 zero bits no effect");
    wr(A_STOP,  16'h0002, '0);
    rd(A_START, 16'h0001, "R3 selective stop");

    // R10 write collides with tick
    wr(A_CNT, 16'd3, 6'h01);
    rd(A_CNT, 16'd3, "R10 write beats tick");
    step(6'h01);
    rd(A_CNT, 16'd4, "R10 count resumes");

    // R7 duty above period
    wr(A_CTRL, 16'h0002, '0);
    wr(A_DUTY, 16'd6, '0);
    chk_pin(1'b0, "R7 c4");
    for (int i = 0; i < 6; i++) begin
      step(6'h01); chk_pin(1'b0, "R7 no compare");
    end

    // R8 abrupt
    wr(A_DUTY, 16'd1, '0);
    wr(A_CNT,  16'd1, '0);
    chk_pin(1'b1, "R8 active before off");
    wr(A_CTRL, 16'h0004, '0);
    chk_pin(1'b0, "R8 abrupt off");
    step(6'h01); chk_pin(1'b0, "R8 stays off c2");

    // R9 graceful: reload count 1, enable, then clear enable
    wr(A_CNT,  16'd1, '0);
    wr(A_CTRL, 16'h0002, '0); chk_pin(1'b1, "R9 enabled c1");
    wr(A_CTRL, 16'h0000, '0); chk_pin(1'b1, "R9 keeps running c1");
    step(6'h01); chk_pin(1'b1, "R9 c2");
    step(6'h01); chk_pin(1'b1, "R9 c3");
    step(6'h01); chk_pin(1'b0, "R9 c4");
    step(6'h01); chk_pin(1'b0, "R9 c0 after wrap");
    step(6'h01); chk_pin(1'b0, "R9 c1 held at init");

    // R11 readback and unimplemented space
    rd(A_CTRL, 16'h0000, "R11 ctrl");
    rd(A_DUTY, 16'd1,    "R11 duty");
    rd(A_PER,  16'd4,    "R11 period");
    wr(6'h1D, 16'h0055, '0);
    rd(6'h1D, 16'h0000, "R11 unimplemented channel");
    rd(6'h03, 16'h0000, "R11 unused global");
    rd(6'h09, 16'h0000, "R11 other channel untouched");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++; $display("FAIL R11 scoreboard actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule